// File: doc/BRIEF.md
# Frame Difference Adaptive Thresholder

This block marks moving pixels in a video stream. Each pixel clock it can take one live pixel and the stored background pixel for the same position. It forms the absolute difference of the red, green and blue components separately. It then compares each difference with a threshold for that component. If any component differs by more than its threshold, the pixel is marked as foreground. The result is a one-bit mask stream with a valid flag, and it can feed a morphology stage.

The thresholds adapt to the scene. While a frame streams through, the block sums the absolute differences of each component. At the next frame sync it divides each sum by the pixel count of the frame, and the resulting mean becomes the new threshold. The threshold applied to a frame is therefore the mean difference of the frame before it. The divide is a shift when the pixel count is a power of two and a multiply by a precomputed reciprocal otherwise.

A small control machine has two states. WAIT_SYNC holds from reset until the first frame sync that arrives with a valid pixel. During WAIT_SYNC the thresholds follow the programmable start value. The transition WAIT_SYNC to SCAN takes place on that first accepted frame sync. SCAN then stays in SCAN on every later cycle, and each accepted frame sync in SCAN closes one frame and opens the next. A frame only updates the thresholds if it was complete; an incomplete frame leaves the previous thresholds in place.

Top module: `motion_mask_gen`

## Requirements
- R1: Each component's difference is the absolute value of live minus background, whichever of the two is larger. In both pixel buses, red is bits [3*CW-1:2*CW], green is bits [2*CW-1:CW] and blue is bits [CW-1:0].
- R2: A component whose difference is strictly greater than its threshold sets `fg_o` to 1, and the three components are ORed. A difference equal to the threshold counts as background.
- R3: Both `fg_valid_o` and `fg_o` are 0 after reset. For every accepted pixel, the result appears on `fg_o` with `fg_valid_o` high after exactly two rising clock edges. On all other cycles `fg_valid_o` is low.
- R4: Pixels that arrive before the first valid frame sync are not accepted and produce no valid output.
- R5: The first frame uses the value of `init_thr_i` present on the cycle of the first accepted frame sync. Later changes to `init_thr_i` have no effect.
- R6: From its first pixel onward, each later frame uses, for each component, the previous frame's sum of differences divided by FRAME_W*FRAME_H and rounded down.
- R7: A frame counts as complete only if it holds exactly FRAME_W*FRAME_H accepted pixels in exactly FRAME_H rows. The frame-sync pixel opens row 1, and each `row_sync_i` on a later accepted pixel opens one more row. After an incomplete frame the previous thresholds are kept.
- R8: Cycles with `pix_valid_i` low produce no valid output and are not counted. Any frame or row sync on such a cycle is ignored.
- R9: The accumulators do not overflow. A complete frame in which every difference is the maximum gives a threshold of 2^CW-1, so maximum-difference pixels in the next frame are background.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid_i | input | 1 | A pixel pair is present this cycle |
| frame_sync_i | input | 1 | This pixel is the first pixel of a frame |
| row_sync_i | input | 1 | This pixel is the first pixel of a row |
| live_rgb_i | input | 3*COMP_W | Live pixel, R/G/B packed high to low |
| bkg_rgb_i | input | 3*COMP_W | Background pixel, same packing |
| init_thr_i | input | 3*COMP_W | Thresholds for the first frame, same packing |
| fg_o | output | 1 | Foreground bit |
| fg_valid_o | output | 1 | `fg_o` carries a result |

## Verification
Each output result is due two rising edges after the edge that accepts its pixel. The bench drives each pixel just after a falling edge and samples one full period later. At that point the output shows the pixel driven on the previous call, so every check is compared with the expectation saved on that previous call. A threshold change takes effect in the same cycle that the frame-sync pixel is registered. For this reason the bench works out the frame-boundary update before it chooses that pixel's value, and boundary probes (equal to the threshold, and one above it) land on the first pixels of each frame.

// File: rtl/mm_pkg.sv
package mm_pkg;
    localparam int NUM_COMP = 3;

    typedef enum logic {
        ST_WAIT_SYNC = 1'b0,
        ST_SCAN      = 1'b1
    } scan_state_e;
endpackage

// File: rtl/mm_absdiff.sv
module mm_absdiff
    import mm_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   accept_i,
    input  logic [NUM_COMP*CW-1:0] live_i,
    input  logic [NUM_COMP*CW-1:0] bkg_i,
    output logic [NUM_COMP*CW-1:0] diff_c_o,
    output logic [NUM_COMP*CW-1:0] diff_q_o,
    output logic                   valid_q_o
);
    for (genvar i = 0; i < NUM_COMP; i++) begin : g_comp
        logic [CW-1:0] a, b;
        assign a = live_i[i*CW +: CW];
        assign b = bkg_i[i*CW +: CW];
        assign diff_c_o[i*CW +: CW] = (a > b) ? (a - b) : (b - a);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            diff_q_o  <= '0;
            valid_q_o <= 1'b0;
        end else begin
            valid_q_o <= accept_i;
            if (accept_i) diff_q_o <= diff_c_o;
        end
    end

    // R3
    stage1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept_i |=> valid_q_o);
endmodule

// File: rtl/mm_frame_stats.sv
module mm_frame_stats
    import mm_pkg::*;
#(
    parameter int CW      = 8,
    parameter int FRAME_W = 1280,
    parameter int FRAME_H = 1024
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   pix_valid_i,
    input  logic                   frame_sync_i,
    input  logic                   row_sync_i,
    input  logic [NUM_COMP*CW-1:0] diff_i,
    input  logic [NUM_COMP*CW-1:0] init_thr_i,
    output logic                   accept_o,
    output logic [NUM_COMP*CW-1:0] thr_o
);
    localparam longint unsigned NPIX  = longint'(FRAME_W) * longint'(FRAME_H);
    localparam longint unsigned MAXS  = NPIX * ((64'd1 << CW) - 1);
    localparam int              ACC_W = $clog2(MAXS + 1);
    localparam int              SHIFT = $clog2(NPIX);
    localparam bit              POW2  = (NPIX & (NPIX - 1)) == 0;
    localparam int              RS    = ACC_W + SHIFT + 1;
    localparam longint unsigned RECIP = ((64'd1 << RS) + NPIX - 1) / NPIX;
    localparam int              PC_W  = $clog2(NPIX + 2);
    localparam int              RC_W  = $clog2(FRAME_H + 2);
    localparam logic [PC_W-1:0] PC_FULL = PC_W'(NPIX);
    localparam logic [PC_W-1:0] PC_OVER = PC_W'(NPIX + 1);
    localparam logic [RC_W-1:0] RC_FULL = RC_W'(FRAME_H);
    localparam logic [RC_W-1:0] RC_OVER = RC_W'(FRAME_H + 1);

    scan_state_e     state_q, state_d;
    logic            start_frame, load_init, take_mean, frame_ok;
    logic [PC_W-1:0] pix_cnt_q;
    logic [RC_W-1:0] row_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WAIT_SYNC;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT_SYNC: if (pix_valid_i && frame_sync_i) state_d = ST_SCAN;
            ST_SCAN:      state_d = ST_SCAN;
        endcase
    end

    always_comb begin
        start_frame = pix_valid_i && frame_sync_i;
        accept_o    = pix_valid_i && (frame_sync_i || state_q == ST_SCAN);
        frame_ok    = (pix_cnt_q == PC_FULL) && (row_cnt_q == RC_FULL);
        load_init   = (state_q == ST_WAIT_SYNC);
        take_mean   = (state_q == ST_SCAN) && start_frame && frame_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pix_cnt_q <= '0;
            row_cnt_q <= '0;
        end else if (start_frame) begin
            pix_cnt_q <= PC_W'(1);
            row_cnt_q <= RC_W'(1);
        end else if (accept_o) begin
            if (pix_cnt_q != PC_OVER) pix_cnt_q <= pix_cnt_q + 1'b1;
            if (row_sync_i && row_cnt_q != RC_OVER) row_cnt_q <= row_cnt_q + 1'b1;
        end
    end

    for (genvar i = 0; i < NUM_COMP; i++) begin : g_comp
        logic [ACC_W-1:0] acc_q;
        logic [CW-1:0]    mean;
        logic [CW-1:0]    d;
        assign d = diff_i[i*CW +: CW];

        if (POW2) begin : g_shift
            assign mean = acc_q[SHIFT +: CW];
        end else begin : g_recip
            localparam logic [RS:0] RCP = (RS+1)'(RECIP);
            logic [ACC_W+RS:0] prod;
            assign prod = {{(RS+1){1'b0}}, acc_q} * {{ACC_W{1'b0}}, RCP};
            assign mean = prod[RS +: CW];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                acc_q               <= '0;
                thr_o[i*CW +: CW]   <= '0;
            end else begin
                if (load_init)      thr_o[i*CW +: CW] <= init_thr_i[i*CW +: CW];
                else if (take_mean) thr_o[i*CW +: CW] <= mean;
                if (start_frame)    acc_q <= {{(ACC_W-CW){1'b0}}, d};
                else if (accept_o)  acc_q <= acc_q + {{(ACC_W-CW){1'b0}}, d};
            end
        end
    end

    // R4
    wait_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_SYNC && !frame_sync_i) |-> !accept_o);
    // R6
    thr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN && !start_frame) |=> $stable(thr_o));
    // R7
    thr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN && start_frame && !frame_ok) |=> $stable(thr_o));
    // R7
    cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_frame |=> (pix_cnt_q == PC_W'(1)));
endmodule

// File: rtl/mm_compare.sv
module mm_compare
    import mm_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   valid_i,
    input  logic [NUM_COMP*CW-1:0] diff_i,
    input  logic [NUM_COMP*CW-1:0] thr_i,
    output logic                   fg_o,
    output logic                   fg_valid_o
);
    logic [NUM_COMP-1:0] above;

    for (genvar i = 0; i < NUM_COMP; i++) begin : g_cmp
        assign above[i] = diff_i[i*CW +: CW] > thr_i[i*CW +: CW];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fg_o       <= 1'b0;
            fg_valid_o <= 1'b0;
        end else begin
            fg_valid_o <= valid_i;
            fg_o       <= valid_i && (|above);
        end
    end

    // R3
    lat_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> !fg_valid_o);
    // R2
    fg_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fg_o |-> fg_valid_o);
endmodule

// File: rtl/motion_mask_gen.sv
module motion_mask_gen
    import mm_pkg::*;
#(
    parameter int COMP_W  = 8,
    parameter int FRAME_W = 1280,
    parameter int FRAME_H = 1024
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       pix_valid_i,
    input  logic                       frame_sync_i,
    input  logic                       row_sync_i,
    input  logic [NUM_COMP*COMP_W-1:0] live_rgb_i,
    input  logic [NUM_COMP*COMP_W-1:0] bkg_rgb_i,
    input  logic [NUM_COMP*COMP_W-1:0] init_thr_i,
    output logic                       fg_o,
    output logic                       fg_valid_o
);
    localparam int BUS_W = NUM_COMP * COMP_W;

    logic             accept;
    logic             s1_valid;
    logic [BUS_W-1:0] diff_now, diff_s1, thr;

    mm_absdiff #(.CW(COMP_W)) u_diff (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept_i  (accept),
        .live_i    (live_rgb_i),
        .bkg_i     (bkg_rgb_i),
        .diff_c_o  (diff_now),
        .diff_q_o  (diff_s1),
        .valid_q_o (s1_valid)
    );

    mm_frame_stats #(.CW(COMP_W), .FRAME_W(FRAME_W), .FRAME_H(FRAME_H)) u_stats (
        .clk          (clk),
        .rst_n        (rst_n),
        .pix_valid_i  (pix_valid_i),
        .frame_sync_i (frame_sync_i),
        .row_sync_i   (row_sync_i),
        .diff_i       (diff_now),
        .init_thr_i   (init_thr_i),
        .accept_o     (accept),
        .thr_o        (thr)
    );

    mm_compare #(.CW(COMP_W)) u_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_i    (s1_valid),
        .diff_i     (diff_s1),
        .thr_i      (thr),
        .fg_o       (fg_o),
        .fg_valid_o (fg_valid_o)
    );

    // R8
    gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid_i |=> ##1 !fg_valid_o);
    // R3
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid_i && frame_sync_i) |=> ##1 fg_valid_o);
endmodule

// File: tb/tb_motion_mask_gen.sv
module tb_motion_mask_gen;
    import mm_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int CW = 8;
    localparam int FW = 4;
    localparam int FH = 3;
    localparam int NPIX = FW * FH;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pix_valid_i = 1'b0, frame_sync_i = 1'b0, row_sync_i = 1'b0;
    logic [3*CW-1:0] live_rgb_i = '0, bkg_rgb_i = '0, init_thr_i = '0;
    logic fg_o, fg_valid_o;

    int n_tests = 0;
    int n_fail  = 0;

    // bench model of the requirements
    int  m_thr[3];
    int  m_sum[3];
    int  m_init[3];
    int  m_pc = 0, m_rc = 0;
    bit  m_in = 0;
    bit  prev_v = 0, prev_fg = 0;
    string prev_req = "R3";

    motion_mask_gen #(.COMP_W(CW), .FRAME_W(FW), .FRAME_H(FH)) dut (
        .clk(clk), .rst_n(rst_n), .pix_valid_i(pix_valid_i),
        .frame_sync_i(frame_sync_i), .row_sync_i(row_sync_i),
        .live_rgb_i(live_rgb_i), .bkg_rgb_i(bkg_rgb_i),
        .init_thr_i(init_thr_i), .fg_o(fg_o), .fg_valid_o(fg_valid_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic set_init(input int r, input int g, input int b);
        m_init[0] = r; m_init[1] = g; m_init[2] = b;
        init_thr_i = {8'(r), 8'(g), 8'(b)};
    endtask

    // sel: 0 given, 1 all equal to thr, 2 red thr+1, 3 blue thr+1 with live<bkg, 5 all max
    task automatic tick(input bit pv, input bit fs, input bit rs, input int sel,
                        input int g0, input int g1, input int g2, input string req);
        int  d[3];
        bit  neg[3];
        bit  acc, efg;
        logic [CW-1:0] lv[3], bk[3];
        if (pv && fs) begin
            if (!m_in) begin
                for (int c = 0; c < 3; c++) m_thr[c] = m_init[c];
            end else if (m_pc == NPIX && m_rc == FH) begin
                for (int c = 0; c < 3; c++) m_thr[c] = m_sum[c] / NPIX;
            end
        end
        acc = pv && (fs || m_in);
        d[0] = g0; d[1] = g1; d[2] = g2;
        neg[0] = 0; neg[1] = 1; neg[2] = 0;
        case (sel)
            1: for (int c = 0; c < 3; c++) d[c] = m_thr[c];
            2: begin
                for (int c = 0; c < 3; c++) d[c] = m_thr[c];
                d[0] = (m_thr[0] < 255) ? m_thr[0] + 1 : 255;
            end
            3: begin
                for (int c = 0; c < 3; c++) d[c] = m_thr[c];
                d[2] = (m_thr[2] < 255) ? m_thr[2] + 1 : 255;
                neg[2] = 1;
            end
            5: for (int c = 0; c < 3; c++) d[c] = 255;
            default: ;
        endcase
        for (int c = 0; c < 3; c++) begin
            if (neg[c]) begin
                lv[c] = CW'((255 - d[c]) / 2); bk[c] = CW'((255 - d[c]) / 2 + d[c]);
            end else begin
                bk[c] = CW'((255 - d[c]) / 2); lv[c] = CW'((255 - d[c]) / 2 + d[c]);
            end
        end
        efg = 0;
        if (acc) begin
            if (fs) begin
                m_in = 1; m_pc = 1; m_rc = 1;
                for (int c = 0; c < 3; c++) m_sum[c] = d[c];
            end else begin
                m_pc++;
                if (rs) m_rc++;
                for (int c = 0; c < 3; c++) m_sum[c] += d[c];
            end
            for (int c = 0; c < 3; c++) if (d[c] > m_thr[c]) efg = 1;
        end
        pix_valid_i = pv; frame_sync_i = fs; row_sync_i = rs;
        live_rgb_i = {lv[0], lv[1], lv[2]};
        bkg_rgb_i  = {bk[0], bk[1], bk[2]};
        @(negedge clk);
        n_tests++;
        if (fg_valid_o !== prev_v) begin
            n_fail++;
            $display("FAIL %s (R3 valid): fg_valid_o=%0b expected %0b", prev_req, fg_valid_o, prev_v);
        end else if (prev_v && fg_o !== prev_fg) begin
            n_fail++;
            $display("FAIL %s: fg_o=%0b expected %0b", prev_req, fg_o, prev_fg);
        end
        prev_v = acc; prev_fg = efg; prev_req = req;
    endtask

    task automatic run_frame(input int rows, input int cols, input bit gap,
                             input bit allmax, input string req);
        int idx = 0;
        for (int r = 0; r < rows; r++) begin
            for (int c = 0; c < cols; c++) begin
                int sel = allmax ? 5 : (idx == 0 ? 1 : (idx == 1 ? 2 : (idx == 2 ? 3 : 0)));
                tick(1'b1, r == 0 && c == 0, c == 0, sel,
                     (idx * 37 + 5) % 256, (idx * 53 + 17) % 256, (idx * 29 + 90) % 256, req);
                if (gap && idx == 4) tick(1'b0, 1'b1, 1'b1, 5, 0, 0, 0, "R8");
                idx++;
            end
        end
    endtask

    task automatic test_reset();
        n_tests++;
        if (fg_valid_o !== 1'b0 || fg_o !== 1'b0) begin
            n_fail++;
            $display("FAIL R3 reset: valid=%0b fg=%0b expected 0 0", fg_valid_o, fg_o);
        end
    endtask

    task automatic test_presync();
        // R4: pixels before the first frame sync are dropped
        for (int i = 0; i < 3; i++) tick(1'b1, 1'b0, i == 0, 5, 0, 0, 0, "R4");
        tick(1'b0, 1'b0, 1'b0, 0, 0, 0, 0, "R8");
    endtask

    task automatic test_first_frame();
        // R5 and R1/R2 probes against the start thresholds
        set_init(10, 20, 30);
        tick(1'b1, 1'b1, 1'b1, 1, 0, 0, 0, "R5");
        set_init(0, 0, 0);
        tick(1'b1, 1'b0, 1'b0, 2, 0, 0, 0, "R2");
        tick(1'b1, 1'b0, 1'b0, 3, 0, 0, 0, "R1");
        tick(1'b1, 1'b0, 1'b0, 0, 9, 21, 25, "R1");
        for (int i = 4; i < NPIX; i++)
            tick(1'b1, 1'b0, (i % FW) == 0, 0, (i * 19) % 256, (i * 7) % 40, (i * 31) % 256, "R5");
    endtask

    task automatic test_mean_frames();
        run_frame(FH, FW, 1'b1, 1'b0, "R6");
        run_frame(FH, FW, 1'b0, 1'b0, "R6");
    endtask

    task automatic test_incomplete();
        run_frame(2, FW, 1'b0, 1'b0, "R7");
        run_frame(FH, FW, 1'b0, 1'b0, "R7");
        run_frame(2, 6, 1'b0, 1'b0, "R7");
        run_frame(FH, FW, 1'b0, 1'b0, "R7");
    endtask

    task automatic test_max();
        run_frame(FH, FW, 1'b0, 1'b1, "R9");
        run_frame(FH, FW, 1'b0, 1'b1, "R9");
        run_frame(FH, FW, 1'b0, 1'b0, "R9");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int c = 0; c < 3; c++) begin m_thr[c] = 0; m_sum[c] = 0; m_init[c] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_presync();
        test_first_frame();
        test_mean_frames();
        test_incomplete();
        test_max();
        tick(1'b0, 1'b0, 1'b0, 0, 0, 0, 0, "R3");
        tick(1'b0, 1'b0, 1'b0, 0, 0, 0, 0, "R3");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule